// File: doc/BRIEF.md
# Memory Address and Data Register Port with Completion Wait

This block sits between a processor's single internal bus and an external memory bus whose access time varies from one access to the next. It holds the memory address register, which loads from the internal bus and drives the memory address lines at all times. It also holds the memory data register. That register can load from the internal bus or from the memory read data lines. It can drive the internal bus or the memory write data lines, and each of those four paths has its own enable.

The control unit starts a read or a write with a one-cycle request. The block raises the matching memory strobe and keeps it raised until the memory answers with a completion pulse. While the control unit sits in a wait step and no completion has arrived, a stall output holds the control unit in place.

A small state machine tracks the access. It has three states:
- `ACC_IDLE`: no access is outstanding.
- `ACC_RD_WAIT`: a read is outstanding.
- `ACC_WR_WAIT`: a write is outstanding.

It has four transitions:
- `ACC_IDLE` to `ACC_RD_WAIT` on a read request.
- `ACC_IDLE` to `ACC_WR_WAIT` on a write request when no read request is present.
- `ACC_RD_WAIT` to `ACC_IDLE` on completion.
- `ACC_WR_WAIT` to `ACC_IDLE` on completion.

Top module: `membus_port`

## Requirements
- R1: After reset, `mem_addr` is 0, the data register is 0, `mem_rd`, `mem_wr` and `stall` are 0.
- R2: When `mar_ld` is high at a clock edge, `mem_addr` shows the low AW bits of `ibus_in` from the next cycle on, and holds them until the next load.
- R3: When `mdr_ld_bus` is high at a clock edge (and R4's capture does not apply), the data register takes `ibus_in`.
- R4: When `mdr_ld_mem` and `mem_mfc` are both high at a clock edge, the data register takes `mem_rdata`; this wins over `mdr_ld_bus`. `mdr_ld_mem` without `mem_mfc` leaves the data register unchanged.
- R5: `ibus_oe` follows `mdr_to_bus` and `mem_wdata_oe` follows `mdr_to_mem` in the same cycle; `ibus_out` and `mem_wdata` always carry the data register.
- R6: In `ACC_IDLE`, a high `rd_req` raises `mem_rd` in that same cycle. `mem_rd` stays high through the cycle in which `mem_mfc` is high and is low in the following cycle unless a new read starts.
- R7: In `ACC_IDLE`, a high `wr_req` with `rd_req` low raises `mem_wr` in that same cycle. `mem_wr` stays high through the cycle in which `mem_mfc` is high and drops afterwards.
- R8: When a read request and a write request arrive together, the read is taken. `mem_rd` and `mem_wr` are never high together.
- R9: A request that arrives while an access is outstanding is ignored. Once the outstanding access completes, no access follows from it.
- R10: `stall` is high exactly when `wait_mfc` is high, an access is outstanding (past its request cycle) and `mem_mfc` is low. It is low in the cycle `mem_mfc` arrives.
- R11: A `mem_mfc` pulse with no access outstanding changes neither strobe nor `stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ibus_in | input | DW | Value currently on the internal bus |
| mar_ld | input | 1 | Load address register from internal bus |
| mdr_ld_bus | input | 1 | Load data register from internal bus |
| mdr_ld_mem | input | 1 | Load data register from memory read data on completion |
| mdr_to_bus | input | 1 | Drive data register onto internal bus |
| mdr_to_mem | input | 1 | Drive data register onto memory write data lines |
| rd_req | input | 1 | Start a memory read |
| wr_req | input | 1 | Start a memory write |
| wait_mfc | input | 1 | Control unit is in a step that waits for completion |
| ibus_out | output | DW | Data register value toward internal bus |
| ibus_oe | output | 1 | Internal bus drive enable |
| mem_addr | output | AW | Memory address lines |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data lines |
| mem_wdata_oe | output | 1 | Memory write data drive enable |
| mem_rdata | input | DW | Memory read data lines |
| mem_mfc | input | 1 | Memory completion pulse |
| stall | output | 1 | Hold the control unit |

## Verification
Three kinds of result have different timing:
- The strobes, the drive enables and `stall` are combinational from the current inputs and state. They are due in the same cycle as the stimulus.
- A request moves the state machine at the next edge, so its effect on `stall` shows one cycle after the request.
- The address and data register contents are due one cycle after the load or capture edge.

The bench changes inputs on the falling edge and checks combinational results shortly after that. It checks registered results on the falling edge after the capturing rising edge. The memory model's completion delay is varied so that the hold and release of the strobes are seen after waits of different lengths.

// File: rtl/membus_pkg.sv
package membus_pkg;
    typedef enum logic [1:0] {
        ACC_IDLE    = 2'd0,
        ACC_RD_WAIT = 2'd1,
        ACC_WR_WAIT = 2'd2
    } acc_state_e;
endpackage

// File: rtl/mbp_addr_reg.sv
module mbp_addr_reg #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] bus_val,
    output logic [AW-1:0] addr
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (load)
            addr <= bus_val[AW-1:0];
    end
endmodule

// File: rtl/mbp_data_reg.sv
module mbp_data_reg #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_bus,
    input  logic          ld_mem,
    input  logic          mfc,
    input  logic [DW-1:0] bus_val,
    input  logic [DW-1:0] mem_val,
    output logic [DW-1:0] value
);
    logic take_mem;
    assign take_mem = ld_mem && mfc;

    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= '0;
        else if (take_mem)
            value <= mem_val;
        else if (ld_bus)
            value <= bus_val;
    end
endmodule

// File: rtl/mbp_access_fsm.sv
module mbp_access_fsm
    import membus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    input  logic wr_req,
    input  logic wait_mfc,
    input  logic mfc,
    output logic rd_strobe,
    output logic wr_strobe,
    output logic stall
);
    acc_state_e state, state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ACC_IDLE;
        else
            state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ACC_IDLE: begin
                if (rd_req)
                    state_nx = ACC_RD_WAIT;
                else if (wr_req)
                    state_nx = ACC_WR_WAIT;
            end
            ACC_RD_WAIT: if (mfc) state_nx = ACC_IDLE;
            ACC_WR_WAIT: if (mfc) state_nx = ACC_IDLE;
            default:     state_nx = ACC_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rd_strobe = 1'b0;
        wr_strobe = 1'b0;
        stall     = 1'b0;
        unique case (state)
            ACC_IDLE: begin
                rd_strobe = rd_req;
                wr_strobe = wr_req && !rd_req;
            end
            ACC_RD_WAIT: begin
                rd_strobe = 1'b1;
                stall     = wait_mfc && !mfc;
            end
            ACC_WR_WAIT: begin
                wr_strobe = 1'b1;
                stall     = wait_mfc && !mfc;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/membus_port.sv
module membus_port #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] ibus_in,
    input  logic          mar_ld,
    input  logic          mdr_ld_bus,
    input  logic          mdr_ld_mem,
    input  logic          mdr_to_bus,
    input  logic          mdr_to_mem,
    input  logic          rd_req,
    input  logic          wr_req,
    input  logic          wait_mfc,
    output logic [DW-1:0] ibus_out,
    output logic          ibus_oe,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_wdata_oe,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_mfc,
    output logic          stall
);
    logic [DW-1:0] mdr_q;

    mbp_addr_reg #(.AW(AW), .DW(DW)) u_mar (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (mar_ld),
        .bus_val (ibus_in),
        .addr    (mem_addr)
    );

    mbp_data_reg #(.DW(DW)) u_mdr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_bus  (mdr_ld_bus),
        .ld_mem  (mdr_ld_mem),
        .mfc     (mem_mfc),
        .bus_val (ibus_in),
        .mem_val (mem_rdata),
        .value   (mdr_q)
    );

    mbp_access_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .wr_req    (wr_req),
        .wait_mfc  (wait_mfc),
        .mfc       (mem_mfc),
        .rd_strobe (mem_rd),
        .wr_strobe (mem_wr),
        .stall     (stall)
    );

    assign ibus_out     = mdr_q;
    assign ibus_oe      = mdr_to_bus;
    assign mem_wdata    = mdr_q;
    assign mem_wdata_oe = mdr_to_mem;
endmodule

// File: rtl/membus_port_chk.sv
module membus_port_chk #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] ibus_in,
    input logic          mar_ld,
    input logic          mdr_ld_mem,
    input logic          wait_mfc,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [DW-1:0] mem_wdata,
    input logic [DW-1:0] mem_rdata,
    input logic          mem_mfc,
    input logic          stall
);
    AST_ADDR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        mar_ld |=> mem_addr == $past(ibus_in[AW-1:0])); // R2

    AST_MEM_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (mdr_ld_mem && mem_mfc) |=> mem_wdata == $past(mem_rdata)); // R4

    AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_mfc) |=> mem_rd); // R6

    AST_WR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_mfc) |=> mem_wr); // R7

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr})); // R8

    AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (wait_mfc && !mem_mfc && (mem_rd || mem_wr))); // R10
endmodule

bind membus_port membus_port_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ibus_in    (ibus_in),
    .mar_ld     (mar_ld),
    .mdr_ld_mem (mdr_ld_mem),
    .wait_mfc   (wait_mfc),
    .mem_addr   (mem_addr),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .mem_mfc    (mem_mfc),
    .stall      (stall)
);

// File: tb/membus_port_tb.sv
`timescale 1ns/1ps
module membus_port_tb;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] ibus_in = '0;
    logic          mar_ld = 0, mdr_ld_bus = 0, mdr_ld_mem = 0;
    logic          mdr_to_bus = 0, mdr_to_mem = 0;
    logic          rd_req = 0, wr_req = 0, wait_mfc = 0;
    logic [DW-1:0] ibus_out, mem_wdata;
    logic          ibus_oe, mem_rd, mem_wr, mem_wdata_oe, stall;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_mfc = 0;

    always #2.5 clk = ~clk;

    membus_port #(.AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ibus_in(ibus_in), .mar_ld(mar_ld),
        .mdr_ld_bus(mdr_ld_bus), .mdr_ld_mem(mdr_ld_mem),
        .mdr_to_bus(mdr_to_bus), .mdr_to_mem(mdr_to_mem),
        .rd_req(rd_req), .wr_req(wr_req), .wait_mfc(wait_mfc),
        .ibus_out(ibus_out), .ibus_oe(ibus_oe), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .mem_wdata_oe(mem_wdata_oe), .mem_rdata(mem_rdata),
        .mem_mfc(mem_mfc), .stall(stall)
    );

    typedef struct {
        string       tag;
        logic [31:0] exp;
    } sb_item_t;

    sb_item_t sb_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // driver side: push an expected result
    task automatic expect_val(input string tag, input logic [31:0] exp);
        sb_item_t it;
        it.tag = tag;
        it.exp = exp;
        sb_q.push_back(it);
    endtask

    // monitor side: pop and compare against what the design shows
    task automatic observe(input logic [31:0] act);
        sb_item_t it;
        n_cmp++;
        if (sb_q.size() == 0) begin
            n_bad++;
            $display("FAIL scoreboard empty act=%h exp=none", act);
        end else begin
            it = sb_q.pop_front();
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s act=%h exp=%h", it.tag, act, it.exp);
            end
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        expect_val(tag, exp);
        observe(act);
    endtask

    task automatic idle_inputs();
        mar_ld = 0; mdr_ld_bus = 0; mdr_ld_mem = 0;
        mdr_to_bus = 0; mdr_to_mem = 0;
        rd_req = 0; wr_req = 0; wait_mfc = 0; mem_mfc = 0;
    endtask

    // advance to the next falling edge, then settle
    task automatic step();
        @(negedge clk);
        #0.5;
    endtask

    // read the data register through the internal bus path
    task automatic peek_mdr(input string tag, input logic [31:0] exp);
        mdr_to_bus = 1; #0.2;
        chk(tag, ibus_out, exp);
        chk({tag, " oe"}, {31'd0, ibus_oe}, 32'd1);
        mdr_to_bus = 0; #0.2;
    endtask

    // full read: address, wait n cycles, completion with data
    task automatic do_read(input logic [AW-1:0] a, input int lat, input logic [31:0] d);
        step(); idle_inputs();
        ibus_in = {{(DW-AW){1'b0}}, a}; mar_ld = 1; rd_req = 1; #0.2;
        chk("R6 rd same cycle", {31'd0, mem_rd}, 32'd1);
        chk("R10 no stall in request cycle", {31'd0, stall}, 32'd0);
        for (int i = 0; i < lat; i++) begin
            step(); idle_inputs(); mdr_ld_mem = 1; wait_mfc = 1; #0.2;
            chk("R2 addr", {16'd0, mem_addr}, {16'd0, a});
            chk("R10 stall while waiting", {31'd0, stall}, 32'd1);
            chk("R6 rd held", {31'd0, mem_rd}, 32'd1);
        end
        step(); idle_inputs(); mdr_ld_mem = 1; wait_mfc = 1;
        mem_mfc = 1; mem_rdata = d; #0.2;
        chk("R10 stall released on mfc", {31'd0, stall}, 32'd0);
        chk("R6 rd high in mfc cycle", {31'd0, mem_rd}, 32'd1);
        step(); idle_inputs(); #0.2;
        chk("R6 rd dropped", {31'd0, mem_rd}, 32'd0);
        peek_mdr("R4 captured read data", d);
    endtask

    initial begin : main
        idle_inputs();
        repeat (3) @(posedge clk);
        step();
        rst_n = 1; #0.2;
        // R1 reset state
        chk("R1 addr", {16'd0, mem_addr}, 32'd0);
        chk("R1 rd", {31'd0, mem_rd}, 32'd0);
        chk("R1 wr", {31'd0, mem_wr}, 32'd0);
        chk("R1 stall", {31'd0, stall}, 32'd0);
        chk("R1 mdr", mem_wdata, 32'd0);

        // reads with several latencies
        do_read(16'h0040, 1, 32'hDEAD_BEEF);
        do_read(16'h1234, 3, 32'h0BAD_F00D);
        do_read(16'hFFFC, 0, 32'h5555_AAAA);

        // R5 enables combinational
        step(); idle_inputs(); #0.2;
        chk("R5 ibus_oe off", {31'd0, ibus_oe}, 32'd0);
        chk("R5 wdata_oe off", {31'd0, mem_wdata_oe}, 32'd0);
        mdr_to_mem = 1; #0.2;
        chk("R5 wdata_oe on", {31'd0, mem_wdata_oe}, 32'd1);
        chk("R5 wdata value", mem_wdata, 32'h5555_AAAA);

        // write sequence
        step(); idle_inputs(); ibus_in = 32'h0000_0080; mar_ld = 1;
        step(); idle_inputs(); ibus_in = 32'h1234_5678; mdr_ld_bus = 1; wr_req = 1; #0.2;
        chk("R7 wr same cycle", {31'd0, mem_wr}, 32'd1);
        chk("R8 no rd during wr", {31'd0, mem_rd}, 32'd0);
        chk("R2 addr for write", {16'd0, mem_addr}, 32'h80);
        for (int i = 0; i < 2; i++) begin
            step(); idle_inputs(); mdr_to_mem = 1; wait_mfc = 1;
            ibus_in = 32'hCAFE_0000; #0.2;
            chk("R3 mdr from bus", mem_wdata, 32'h1234_5678);
            chk("R7 wr held", {31'd0, mem_wr}, 32'd1);
            chk("R10 stall write", {31'd0, stall}, 32'd1);
        end
        // R9 request during pending write is ignored
        step(); idle_inputs(); mdr_to_mem = 1; wait_mfc = 1; rd_req = 1; #0.2;
        chk("R9 rd ignored while write pending", {31'd0, mem_rd}, 32'd0);
        step(); idle_inputs(); mdr_to_mem = 1; wait_mfc = 1; mem_mfc = 1; #0.2;
        chk("R10 write stall release", {31'd0, stall}, 32'd0);
        chk("R7 wr in mfc cycle", {31'd0, mem_wr}, 32'd1);
        step(); idle_inputs(); #0.2;
        chk("R7 wr dropped", {31'd0, mem_wr}, 32'd0);
        chk("R9 no access after ignored req", {31'd0, mem_rd}, 32'd0);
        step(); #0.2;
        chk("R9 still idle", {31'd0, mem_rd | mem_wr}, 32'd0);

        // R8 simultaneous requests: read wins
        step(); idle_inputs(); rd_req = 1; wr_req = 1; #0.2;
        chk("R8 rd wins", {31'd0, mem_rd}, 32'd1);
        chk("R8 wr suppressed", {31'd0, mem_wr}, 32'd0);
        step(); idle_inputs(); wait_mfc = 1; #0.2;
        chk("R8 read outstanding", {31'd0, mem_rd}, 32'd1);
        chk("R8 write not outstanding", {31'd0, mem_wr}, 32'd0);
        // R4 ld_mem without mfc leaves mdr unchanged
        step(); idle_inputs(); wait_mfc = 1; mdr_ld_mem = 1; mem_rdata = 32'h7777_7777; #0.2;
        chk("R4 no capture yet", mem_wdata, 32'h1234_5678);
        // R4 capture wins over bus load
        step(); idle_inputs(); mdr_ld_mem = 1; mdr_ld_bus = 1; ibus_in = 32'h9999_9999;
        mem_mfc = 1; mem_rdata = 32'h4242_4242;
        step(); idle_inputs(); #0.2;
        chk("R4 capture beats bus load", mem_wdata, 32'h4242_4242);
        chk("R4 unchanged value not taken", {31'd0, mem_wdata == 32'h7777_7777}, 32'd0);

        // R11 stray completion in idle
        step(); idle_inputs(); mem_mfc = 1; wait_mfc = 1; #0.2;
        chk("R11 stall stays low", {31'd0, stall}, 32'd0);
        step(); idle_inputs(); wait_mfc = 1; #0.2;
        chk("R11 no strobe", {31'd0, mem_rd | mem_wr}, 32'd0);
        chk("R11 no stall after", {31'd0, stall}, 32'd0);

        // R10 no stall without wait step while pending
        step(); idle_inputs(); wr_req = 1;
        step(); idle_inputs(); #0.2;
        chk("R10 no stall without wait", {31'd0, stall}, 32'd0);
        wait_mfc = 1; #0.2;
        chk("R10 stall with wait", {31'd0, stall}, 32'd1);
        step(); idle_inputs(); mem_mfc = 1;
        step(); idle_inputs(); #0.2;
        chk("R7 write closed", {31'd0, mem_wr}, 32'd0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule